// File: doc/BRIEF.md
# Hub Downstream Port Resume Sequencer

This block serves the downstream ports of a USB hub that have been selectively suspended while the hub itself stays awake. It watches each port's line state and spots a resume request from the attached device. It answers that request in hardware by driving K on the port. It flags the port in a resume status byte and pulses the hub interrupt. When the selective-suspend bit for that port is cleared, the block completes the end-of-resume waveform by itself: K until at least the minimum resume time has passed, then SE0 for two low-speed bit times, then J for one bit time, then an idle step. Only after the idle step is the port allowed to carry traffic again.

A single sequencer is shared by all ports. A request that arrives while another port is being serviced is recorded and handled as soon as the running sequence ends. When several ports are waiting, the lowest port index is served first. Line states pass through a synchronizer and a glitch filter before detection, so short K pulses never start a resume.

Top module: `hub_resume_seq`

## Requirements
- R1: After reset, every resume status bit is 0, every port drive is hi-Z (code 00), the interrupt is low and every port enable is high.
- R2: On a port whose suspend bit is 1 and which is neither waiting nor in service, a K line state (code 10; J is 01, SE0 is 00) held for 2*BIT_CYCLES consecutive cycles sets that port's status bit. The bit becomes visible 2*BIT_CYCLES+SYNC_STAGES cycles after K first appears at the input. A shorter K, or any K on a port whose suspend bit is 0, leaves the status bit at 0.
- R3: Status bit p belongs to port p. Bits NUM_PORTS through 7 always read 0. A status bit reads 0 in the cycle after its port's suspend bit is 0.
- R4: The interrupt is high for exactly the cycles in which at least one status bit rises. Detections on several ports in the same cycle give a single pulse.
- R5: Drive K (code 10) starts on the detected port one cycle after its status bit rises, if no other port is in service. It continues for as long as the suspend bit stays set.
- R6: If the suspend bit is cleared after h cycles of K, the total K length is max(K_MIN_CYCLES, h+1). It is never shorter than K_MIN_CYCLES.
- R7: SE0 (drive code 11) follows K directly and lasts exactly 2*BIT_CYCLES cycles.
- R8: J (drive code 01) follows SE0 for exactly BIT_CYCLES cycles. It is followed by BIT_CYCLES cycles of hi-Z idle.
- R9: The port enable of a port is low from the cycle its status bit rises until the end of its idle step. It is high again in the next cycle.
- R10: At most one port drives a non-hi-Z code at any time. A port detected while another is in service keeps its status bit, stays hi-Z and disabled, and is served next. Among waiting ports, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (one low-speed bit = BIT_CYCLES cycles) |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state_i | input | 2*NUM_PORTS | Per-port raw line state, 2 bits per port: 00 SE0, 01 J, 10 K |
| suspend_i | input | NUM_PORTS | Per-port selective-suspend control bit |
| drive_o | output | 2*NUM_PORTS | Per-port drive: 00 hi-Z, 01 J, 10 K, 11 SE0 |
| port_enable_o | output | NUM_PORTS | Per-port enable; low while a resume is pending or running |
| resume_status_o | output | 8 | Resume status byte, bit p for port p, upper bits 0 |
| hub_irq_o | output | 1 | Hub interrupt pulse on a new resume detection |

## Verification
Two overlaps matter here. The first is detection on two ports in the same cycle. The second is a fresh detection landing while another port's sequence is running. The bench drives K onto two suspended ports on the same edge. It then expects both status bits and a single interrupt pulse in one cycle, with the lower port driving K and the other port held hi-Z and disabled. The waiting port must then receive a complete, correctly timed sequence of its own once the first sequence ends.

// File: rtl/hub_rsm_pkg.sv
package hub_rsm_pkg;

   // per-port drive codes
   typedef enum logic [1:0] {
      DRV_HIZ = 2'b00,
      DRV_J   = 2'b01,
      DRV_K   = 2'b10,
      DRV_SE0 = 2'b11
   } drive_e;

   // observed line-state codes
   localparam logic [1:0] LINE_SE0 = 2'b00;
   localparam logic [1:0] LINE_J   = 2'b01;
   localparam logic [1:0] LINE_K   = 2'b10;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_HOLD_K,
      SQ_FINISH_K,
      SQ_SE0,
      SQ_J,
      SQ_REST
   } seq_state_e;

endpackage

// File: rtl/hub_rsm_sync.sv
module hub_rsm_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/hub_rsm_detect.sv
module hub_rsm_detect
   import hub_rsm_pkg::*;
#(
   parameter int FILTER_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_i,
   input  logic       suspend_i,
   input  logic       busy_i,
   output logic       fire_o,
   output logic       status_o
);

   localparam int FW = $clog2(FILTER_CYCLES);
   localparam logic [FW-1:0] FILT_LAST = FW'(FILTER_CYCLES - 1);

   logic [FW-1:0] run_q;
   logic          status_q;
   logic          armed;

   assign armed  = suspend_i && !status_q && !busy_i && (line_i == LINE_K);
   assign fire_o = armed && (run_q == FILT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= '0;
         status_q <= 1'b0;
      end else begin
         status_q <= suspend_i && (status_q || fire_o);
         if (armed && run_q != FILT_LAST) run_q <= run_q + 1'b1;
         else                             run_q <= '0;
      end
   end

   assign status_o = status_q;

endmodule

// File: rtl/hub_rsm_seq.sv
module hub_rsm_seq
   import hub_rsm_pkg::*;
#(
   parameter int NUM_PORTS    = 4,
   parameter int BIT_CYCLES   = 8,
   parameter int K_MIN_CYCLES = 120000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_PORTS-1:0]   fire_i,
   input  logic [NUM_PORTS-1:0]   suspend_i,
   output logic [2*NUM_PORTS-1:0] drive_o,
   output logic [NUM_PORTS-1:0]   busy_o
);

   localparam int IW      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
   localparam int KW      = $clog2(K_MIN_CYCLES);
   localparam int SE0_LEN = 2 * BIT_CYCLES;
   localparam int PW      = $clog2(SE0_LEN);
   localparam logic [KW-1:0] K_LAST   = KW'(K_MIN_CYCLES - 1);
   localparam logic [PW-1:0] SE0_LAST = PW'(SE0_LEN - 1);
   localparam logic [PW-1:0] BIT_LAST = PW'(BIT_CYCLES - 1);

   seq_state_e           state_q;
   logic [IW-1:0]        cur_q;
   logic [NUM_PORTS-1:0] pending_q;
   logic [KW-1:0]        k_cnt_q;
   logic [PW-1:0]        ph_q;

   logic [IW-1:0]        pick_idx;
   logic                 pick_vld;
   logic [NUM_PORTS-1:0] grant;
   drive_e               cur_code;
   logic [NUM_PORTS-1:0] active;

   // lowest waiting index wins
   always_comb begin
      pick_idx = '0;
      pick_vld = |pending_q;
      for (int i = NUM_PORTS - 1; i >= 0; i--) begin
         if (pending_q[i]) pick_idx = IW'(i);
      end
   end

   always_comb begin
      grant = '0;
      if (state_q == SQ_IDLE && pick_vld) grant[pick_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         cur_q     <= '0;
         pending_q <= '0;
         k_cnt_q   <= '0;
         ph_q      <= '0;
      end else begin
         pending_q <= (pending_q | fire_i) & ~grant;
         unique case (state_q)
            SQ_IDLE: begin
               if (pick_vld) begin
                  cur_q   <= pick_idx;
                  k_cnt_q <= '0;
                  state_q <= SQ_HOLD_K;
               end
            end
            SQ_HOLD_K: begin
               if (k_cnt_q != K_LAST) k_cnt_q <= k_cnt_q + 1'b1;
               if (!suspend_i[cur_q]) state_q <= SQ_FINISH_K;
            end
            SQ_FINISH_K: begin
               if (k_cnt_q == K_LAST) begin
                  state_q <= SQ_SE0;
                  ph_q    <= '0;
               end else begin
                  k_cnt_q <= k_cnt_q + 1'b1;
               end
            end
            SQ_SE0: begin
               if (ph_q == SE0_LAST) begin
                  state_q <= SQ_J;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SQ_J: begin
               if (ph_q == BIT_LAST) begin
                  state_q <= SQ_REST;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SQ_REST: begin
               if (ph_q == BIT_LAST) begin
                  state_q <= SQ_IDLE;
                  ph_q    <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         SQ_HOLD_K, SQ_FINISH_K: cur_code = DRV_K;
         SQ_SE0:                 cur_code = DRV_SE0;
         SQ_J:                   cur_code = DRV_J;
         default:                cur_code = DRV_HIZ;
      endcase
   end

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         assign active[p]       = (state_q != SQ_IDLE) && (cur_q == IW'(p));
         assign drive_o[2*p +: 2] = active[p] ? cur_code : DRV_HIZ;
         assign busy_o[p]       = pending_q[p] | active[p];
      end
   endgenerate

endmodule

// File: rtl/hub_resume_seq.sv
module hub_resume_seq
   import hub_rsm_pkg::*;
#(
   parameter int NUM_PORTS    = 4,
   parameter int BIT_CYCLES   = 8,
   parameter int K_MIN_CYCLES = 120000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2*NUM_PORTS-1:0] line_state_i,
   input  logic [NUM_PORTS-1:0]   suspend_i,
   output logic [2*NUM_PORTS-1:0] drive_o,
   output logic [NUM_PORTS-1:0]   port_enable_o,
   output logic [7:0]             resume_status_o,
   output logic                   hub_irq_o
);

   localparam int FILTER_CYCLES = 2 * BIT_CYCLES;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > 7) begin : g_bad_ports
         $error("hub_resume_seq: NUM_PORTS must be 1..7");
      end
      if (BIT_CYCLES < 1) begin : g_bad_bit
         $error("hub_resume_seq: BIT_CYCLES must be at least 1");
      end
      if (K_MIN_CYCLES < 2) begin : g_bad_kmin
         $error("hub_resume_seq: K_MIN_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hub_resume_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2*NUM_PORTS-1:0] line_sync;
   logic [NUM_PORTS-1:0]   fire;
   logic [NUM_PORTS-1:0]   status;
   logic [NUM_PORTS-1:0]   busy;
   logic                   irq_q;

   hub_rsm_sync #(
      .WIDTH  (2 * NUM_PORTS),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (line_state_i),
      .sync_o  (line_sync)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_det
         hub_rsm_detect #(
            .FILTER_CYCLES (FILTER_CYCLES)
         ) det_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_i    (line_sync[2*p +: 2]),
            .suspend_i (suspend_i[p]),
            .busy_i    (busy[p]),
            .fire_o    (fire[p]),
            .status_o  (status[p])
         );
      end
   endgenerate

   hub_rsm_seq #(
      .NUM_PORTS    (NUM_PORTS),
      .BIT_CYCLES   (BIT_CYCLES),
      .K_MIN_CYCLES (K_MIN_CYCLES)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .suspend_i (suspend_i),
      .drive_o   (drive_o),
      .busy_o    (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |fire;
   end

   generate
      for (genvar b = 0; b < 8; b++) begin : g_stat
         if (b < NUM_PORTS) begin : g_used
            assign resume_status_o[b] = status[b];
         end else begin : g_unused
            assign resume_status_o[b] = 1'b0;
         end
      end
   endgenerate

   assign port_enable_o = ~busy;
   assign hub_irq_o     = irq_q;

endmodule

// File: rtl/hub_resume_seq_chk.sv
module hub_resume_seq_chk
   import hub_rsm_pkg::*;
#(
   parameter int NUM_PORTS    = 4,
   parameter int K_MIN_CYCLES = 120000
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_PORTS-1:0]   suspend_i,
   input logic [2*NUM_PORTS-1:0] drive_o,
   input logic [NUM_PORTS-1:0]   port_enable_o,
   input logic [7:0]             resume_status_o,
   input logic                   hub_irq_o
);

   logic [NUM_PORTS-1:0] k_vec, se0_vec, j_vec, act_vec;
   int unsigned          k_run;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
         assign k_vec[p]   = drive_o[2*p +: 2] == DRV_K;
         assign se0_vec[p] = drive_o[2*p +: 2] == DRV_SE0;
         assign j_vec[p]   = drive_o[2*p +: 2] == DRV_J;
         assign act_vec[p] = drive_o[2*p +: 2] != DRV_HIZ;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        k_run <= 0;
      else if (|k_vec)   k_run <= k_run + 1;
      else               k_run <= 0;
   end

   assert_status_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((resume_status_o[NUM_PORTS-1:0] & ~$past(suspend_i)) == '0));

   assert_irq_on_new_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hub_irq_o |-> ((resume_status_o & ~$past(resume_status_o)) != 8'h00));

   assert_single_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_vec));

   assert_driven_port_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vec & port_enable_o) == '0);

   assert_k_long_enough_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((se0_vec & ~$past(se0_vec)) != '0) |-> (k_run >= K_MIN_CYCLES));

   assert_se0_follows_k_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((se0_vec & ~$past(se0_vec)) != '0) |-> ((se0_vec & ~$past(se0_vec)) == $past(k_vec)));

   assert_j_follows_se0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((j_vec & ~$past(j_vec)) != '0) |-> ((j_vec & ~$past(j_vec)) == $past(se0_vec)));

endmodule

bind hub_resume_seq hub_resume_seq_chk #(
   .NUM_PORTS    (NUM_PORTS),
   .K_MIN_CYCLES (K_MIN_CYCLES)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .suspend_i       (suspend_i),
   .drive_o         (drive_o),
   .port_enable_o   (port_enable_o),
   .resume_status_o (resume_status_o),
   .hub_irq_o       (hub_irq_o)
);

// File: tb/hub_resume_seq_tb_top.sv
module hub_resume_seq_tb_top;
   import hub_rsm_pkg::*;

   localparam int NP   = 3;
   localparam int BC   = 8;
   localparam int KM   = 300;
   localparam int SYN  = 2;
   localparam int DET  = 2 * BC;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2*NP-1:0] line_state;
   logic [NP-1:0]   susp;
   logic [2*NP-1:0] drive_o;
   logic [NP-1:0]   port_enable_o;
   logic [7:0]      resume_status_o;
   logic            hub_irq_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cycles++;

   hub_resume_seq #(
      .NUM_PORTS    (NP),
      .BIT_CYCLES   (BC),
      .K_MIN_CYCLES (KM),
      .SYNC_STAGES  (SYN)
   ) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .line_state_i    (line_state),
      .suspend_i       (susp),
      .drive_o         (drive_o),
      .port_enable_o   (port_enable_o),
      .resume_status_o (resume_status_o),
      .hub_irq_o       (hub_irq_o)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_k_len(input int hold);
      return (hold + 1 > KM) ? hold + 1 : KM;
   endfunction

   function automatic bit exp_detect(input int len);
      return len >= DET;
   endfunction

   function automatic logic [1:0] drv(input int p);
      return drive_o[2*p +: 2];
   endfunction

   task automatic set_line(input int p, input logic [1:0] v);
      line_state[2*p +: 2] = v;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // K for len cycles on port p; returns on the sample where the status bit appears
   task automatic pulse_k(input int p, input int len, output bit fired, output int latency);
      int n;
      fired   = 1'b0;
      latency = 0;
      n       = 0;
      @(negedge clk);
      set_line(p, LINE_K);
      while (!fired && n < DET + SYN + 4) begin
         @(negedge clk);
         n++;
         if (resume_status_o[p]) begin
            fired   = 1'b1;
            latency = n;
         end
         if (n == len) set_line(p, LINE_J);
      end
      set_line(p, LINE_J);
   endtask

   // follows one port's sequence; clears its suspend bit after hold K cycles (hold>0)
   task automatic measure_seq(input int p, input int hold);
      int guard, klen, se0len, jlen, restlen, other_bad, en_bad;
      guard = 0; klen = 0; se0len = 0; jlen = 0; restlen = 0; other_bad = 0; en_bad = 0;
      while (drv(p) != DRV_K && guard < 5000) begin @(negedge clk); guard++; end
      while (drv(p) == DRV_K && guard < 5000) begin
         klen++;
         for (int q = 0; q < NP; q++) if (q != p && drv(q) != DRV_HIZ) other_bad++;
         if (port_enable_o[p]) en_bad++;
         if (hold > 0 && klen == hold)
            check(resume_status_o[p] == 1'b1, "R5", "status while suspend held", resume_status_o[p], 1);
         if (hold > 0 && klen == hold + 1)
            check(resume_status_o[p] == 1'b0, "R3", "status after suspend cleared", resume_status_o[p], 0);
         if (klen == hold) susp[p] = 1'b0;
         @(negedge clk); guard++;
      end
      while (drv(p) == DRV_SE0 && guard < 5000) begin
         se0len++;
         if (port_enable_o[p]) en_bad++;
         @(negedge clk); guard++;
      end
      while (drv(p) == DRV_J && guard < 5000) begin
         jlen++;
         if (port_enable_o[p]) en_bad++;
         @(negedge clk); guard++;
      end
      while (drv(p) == DRV_HIZ && !port_enable_o[p] && guard < 5000) begin
         restlen++;
         @(negedge clk); guard++;
      end
      check(klen == exp_k_len(hold), "R6", "K length", klen, exp_k_len(hold));
      check(se0len == 2 * BC, "R7", "SE0 length", se0len, 2 * BC);
      check(jlen == BC, "R8", "J length", jlen, BC);
      check(restlen == BC, "R8", "idle step length", restlen, BC);
      check(port_enable_o[p] == 1'b1, "R9", "enable after idle step", port_enable_o[p], 1);
      check(en_bad == 0, "R9", "enable low during sequence", en_bad, 0);
      check(other_bad == 0, "R10", "other ports hi-Z during K", other_bad, 0);
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      wait (cycles >= 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
         report();
         $finish;
      end
   end

   initial begin
      bit fired, fired2;
      int lat, p, len, hold;
      void'($urandom(32'd4711));
      for (int i = 0; i < NP; i++) line_state[2*i +: 2] = LINE_J;
      susp = '0;
      idle_cycles(4);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(resume_status_o == 8'h00, "R1", "status after reset", resume_status_o, 0);
      check(drive_o == '0, "R1", "drive after reset", drive_o, 0);
      check(hub_irq_o == 1'b0, "R1", "irq after reset", hub_irq_o, 0);
      check(port_enable_o == '1, "R1", "enable after reset", port_enable_o, 7);

      // R2 K on a port that is not suspended is ignored
      pulse_k(0, 40, fired, lat);
      check(!fired, "R2", "detect on unsuspended port", fired, 0);
      check(drive_o == '0, "R2", "drive after unsuspended K", drive_o, 0);
      check(port_enable_o == '1, "R2", "enable after unsuspended K", port_enable_o, 7);

      // R2 glitch one cycle short of the filter
      susp[1] = 1'b1;
      pulse_k(1, DET - 1, fired, lat);
      check(!fired, "R2", "short glitch ignored", fired, 0);
      idle_cycles(4);
      check(drive_o == '0, "R2", "drive after glitch", drive_o, 0);

      // R2 exact filter length; R4, R9, R3, R5
      pulse_k(1, DET, fired, lat);
      check(fired, "R2", "detect at filter length", fired, 1);
      check(lat == DET + SYN, "R2", "detect latency", lat, DET + SYN);
      check(hub_irq_o == 1'b1, "R4", "irq with status", hub_irq_o, 1);
      check(port_enable_o[1] == 1'b0, "R9", "enable drops with status", port_enable_o[1], 0);
      check(resume_status_o[7:NP] == '0, "R3", "upper status bits", resume_status_o[7:NP], 0);
      check(drv(1) == DRV_HIZ, "R5", "drive before K start", drv(1), DRV_HIZ);
      @(negedge clk);
      check(hub_irq_o == 1'b0, "R4", "irq single pulse", hub_irq_o, 0);
      check(drv(1) == DRV_K, "R5", "K starts next cycle", drv(1), DRV_K);
      measure_seq(1, 50);
      idle_cycles(5);

      // R6 long hold
      susp[2] = 1'b1;
      pulse_k(2, DET + 3, fired, lat);
      check(fired, "R2", "detect port 2", fired, 1);
      measure_seq(2, KM + 40);
      idle_cycles(5);

      // R10 two ports detected in the same cycle
      susp[0] = 1'b1;
      susp[2] = 1'b1;
      @(negedge clk);
      set_line(0, LINE_K);
      set_line(2, LINE_K);
      fired = 1'b0;
      lat = 0;
      while (!fired && lat < DET + SYN + 4) begin
         @(negedge clk);
         lat++;
         fired = resume_status_o[0];
      end
      fired2 = resume_status_o[2];
      set_line(0, LINE_J);
      set_line(2, LINE_J);
      check(fired && fired2, "R10", "both status bits same cycle", {fired, fired2}, 3);
      check(hub_irq_o == 1'b1, "R4", "irq for joint detection", hub_irq_o, 1);
      check(port_enable_o[0] == 1'b0 && port_enable_o[2] == 1'b0, "R9", "both ports disabled",
            port_enable_o, 2);
      @(negedge clk);
      check(hub_irq_o == 1'b0, "R4", "one pulse for joint detection", hub_irq_o, 0);
      check(drv(0) == DRV_K, "R10", "lower port served first", drv(0), DRV_K);
      check(drv(2) == DRV_HIZ, "R10", "waiting port hi-Z", drv(2), DRV_HIZ);
      measure_seq(0, 30);
      check(resume_status_o[2] == 1'b1, "R10", "waiting status kept", resume_status_o[2], 1);
      measure_seq(2, 10);
      idle_cycles(5);

      // random lengths and holds
      for (int it = 0; it < 10; it++) begin
         p    = $urandom_range(NP - 1, 0);
         len  = $urandom_range(DET + 6, DET - 4);
         hold = $urandom_range(KM + 60, 0);
         susp[p] = 1'b1;
         pulse_k(p, len, fired, lat);
         check(fired == exp_detect(len), "R2", "random detect", fired, exp_detect(len));
         if (fired) begin
            if (hold == 0) susp[p] = 1'b0;
            measure_seq(p, hold);
         end else begin
            susp[p] = 1'b0;
         end
         idle_cycles(6);
         check(resume_status_o == 8'h00, "R3", "status idle between runs", resume_status_o, 0);
      end

      done = 1'b1;
      report();
      $finish;
   end

endmodule